// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block sits beside a small CPU core and decides when the core should be interrupted and at which level. Eight request lines feed it. Level 7 has the highest priority and level 0 the lowest. Requests are captured into a pending register, but only on instruction-cycle strobes that the core marks as non-I/O cycles. A second register records which levels are currently being serviced, so that interrupts can nest.

The controller raises its request output when three things hold: the global enable is set, something is pending, and the highest pending level is strictly above every active level. With the request it reports the highest pending level number. An acknowledge from the core moves that level from pending to active. A return-from-interrupt retires the highest active level. This lets a lower or equal level that was held back come forward. Vector fetch and context save belong to the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset both registers are empty, so `irqReq` is 0 and `irqLevel` is 0, whatever the inputs do before the first sampling strobe.
- R2: Request lines are latched into pending only on a clock edge where `cycleStb` is 1 and `ioCycle` is 0. A strobe with `ioCycle` = 1, or no strobe at all, captures nothing.
- R3: A pending bit stays set after its request line drops, until that level is acknowledged.
- R4: `irqReq` is 0 whenever `intEnable` is 0. When `intEnable` returns to 1, a waiting request is presented again.
- R5: `irqLevel` gives the index of the highest set pending bit, as an unsigned 3-bit number.
- R6: Bit index equals priority: level 7 beats every other level, and level 0 loses to all of them.
- R7: `irqAck` while `irqReq` is 1 clears the pending bit at `irqLevel` and sets the same active bit on that clock edge.
- R8: A pending level higher than every active level raises `irqReq`, so a higher level can nest into a lower one being serviced.
- R9: A pending level equal to or below the highest active level keeps `irqReq` at 0 and stays pending.
- R10: `retInt` clears only the highest set active bit. The next-highest active level then governs nesting.
- R11: `irqAck` while `irqReq` is 0 has no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Request lines, bit n is level n |
| cycleStb | input | 1 | Marks the clock in which an instruction cycle completes |
| ioCycle | input | 1 | Qualifies the strobe as an I/O instruction cycle |
| intEnable | input | 1 | Global interrupt enable |
| irqAck | input | 1 | Core accepts the presented level |
| retInt | input | 1 | Core returns from the current handler |
| irqReq | output | 1 | Interrupt request to the core |
| irqLevel | output | 3 | Highest pending level |

## Verification
The bench builds the controller at its default of eight levels. This puts both ends of the priority range within reach: level 7 nesting over level 5, and level 0 waiting behind everything. The directed tasks cover gating of capture by I/O cycles and by the enable. They also cover deferral of equal and lower levels while a level is active, and the release of the next level after each return. An acknowledge given while nothing is presented is checked at the ports as well.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef struct packed {
    logic sample;
    logic ack;
    logic ret;
  } irqStb_t;
endpackage

// File: rtl/prio_enc.sv
module prio_enc #(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IDX_W-1:0] topIdx,
  output logic             anySet
);
  always_comb begin
    topIdx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) topIdx = IDX_W'(i);
    end
    anySet = |vec;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] irqIn,
  input  irqStb_t               stb,
  output logic [LVL_W-1:0]      pendHi,
  output logic                  pendAny,
  output logic [LVL_W-1:0]      actHi,
  output logic                  actAny
);
  localparam logic [NUM_LEVELS-1:0] ONE = NUM_LEVELS'(1);

  logic [NUM_LEVELS-1:0] pending, active;
  logic [NUM_LEVELS-1:0] sampleMask, ackMask, retMask, pendNext, actNext;

  always_comb begin
    sampleMask = stb.sample ? irqIn : '0;
    ackMask    = stb.ack ? (ONE << pendHi) : '0;
    retMask    = stb.ret ? (ONE << actHi) : '0;
    pendNext   = (pending & ~ackMask) | sampleMask;
    actNext    = (active & ~retMask) | ackMask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      active  <= '0;
    end else begin
      pending <= pendNext;
      active  <= actNext;
    end
  end

  prio_enc #(.WIDTH(NUM_LEVELS)) u_pendEnc (.vec(pending), .topIdx(pendHi), .anySet(pendAny));
  prio_enc #(.WIDTH(NUM_LEVELS)) u_actEnc  (.vec(active),  .topIdx(actHi),  .anySet(actAny));

  p_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.sample |=> ((pending & ~$past(pending)) == '0));
  p_pending_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.ack |=> (($past(pending) & ~pending) == '0));
  p_ack_sets_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.ack |=> active[$past(pendHi)]);
  p_ack_clears_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.ack && !stb.sample) |=> !pending[$past(pendHi)]);
  p_ret_clears_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.ret && !stb.ack) |=> !active[$past(actHi)]);
  p_active_grows_by_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.ack |=> ($countones(active) <= $countones($past(active))));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycleStb,
  input  logic             ioCycle,
  input  logic             intEnable,
  input  logic             irqAck,
  input  logic             retInt,
  input  logic [LVL_W-1:0] pendHi,
  input  logic             pendAny,
  input  logic [LVL_W-1:0] actHi,
  input  logic             actAny,
  output irqStb_t          stb,
  output logic             irqReq
);
  logic aboveActive;

  always_comb begin
    aboveActive = !actAny || (pendHi > actHi);
    irqReq      = intEnable && pendAny && aboveActive;
    stb.sample  = cycleStb && !ioCycle;
    stb.ack     = irqAck && irqReq;
    stb.ret     = retInt && actAny;
  end

  p_req_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> intEnable);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] irqIn,
  input  logic                  cycleStb,
  input  logic                  ioCycle,
  input  logic                  intEnable,
  input  logic                  irqAck,
  input  logic                  retInt,
  output logic                  irqReq,
  output logic [LVL_W-1:0]      irqLevel
);
  irqStb_t          stb;
  logic [LVL_W-1:0] pendHi, actHi;
  logic             pendAny, actAny;

  irq_ctrl #(.NUM_LEVELS(NUM_LEVELS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cycleStb(cycleStb), .ioCycle(ioCycle),
    .intEnable(intEnable), .irqAck(irqAck), .retInt(retInt),
    .pendHi(pendHi), .pendAny(pendAny), .actHi(actHi), .actAny(actAny),
    .stb(stb), .irqReq(irqReq));

  irq_datapath #(.NUM_LEVELS(NUM_LEVELS)) u_dp (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .stb(stb),
    .pendHi(pendHi), .pendAny(pendAny), .actHi(actHi), .actAny(actAny));

  assign irqLevel = pendHi;
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] irqIn = '0;
  logic       cycleStb = 0, ioCycle = 0, intEnable = 0, irqAck = 0, retInt = 0;
  logic       irqReq;
  logic [2:0] irqLevel;
  int         checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .cycleStb(cycleStb),
    .ioCycle(ioCycle), .intEnable(intEnable), .irqAck(irqAck),
    .retInt(retInt), .irqReq(irqReq), .irqLevel(irqLevel));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_out(string req, logic r, int lvl);
    chk({req, " irqReq"}, int'(irqReq), int'(r));
    if (r) chk({req, " irqLevel"}, int'(irqLevel), lvl);
  endtask

  task automatic cyc(logic [7:0] irq, logic s, logic io, logic a, logic rt);
    @(negedge clk);
    irqIn = irq; cycleStb = s; ioCycle = io; irqAck = a; retInt = rt;
    @(posedge clk);
    #1;
    irqIn = '0; cycleStb = 0; ioCycle = 0; irqAck = 0; retInt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; intEnable = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    irqIn = 8'hFF;
    @(posedge clk); #1;
    chk("R1 irqReq", int'(irqReq), 0);
    chk("R1 irqLevel", int'(irqLevel), 0);
    irqIn = '0;
  endtask

  task automatic t_sampling();
    do_reset();
    cyc(8'h10, 1, 1, 0, 0);
    expect_out("R2 io cycle", 0, 0);
    cyc(8'h10, 0, 0, 0, 0);
    expect_out("R2 no strobe", 0, 0);
    cyc(8'h10, 1, 0, 0, 0);
    expect_out("R2 capture", 1, 4);
    cyc(8'h00, 1, 0, 0, 0);
    expect_out("R3 sticky", 1, 4);
  endtask

  task automatic t_enable();
    do_reset();
    intEnable = 0;
    cyc(8'h01, 1, 0, 0, 0);
    expect_out("R4 disabled", 0, 0);
    intEnable = 1;
    #1;
    expect_out("R4 re-enabled", 1, 0);
  endtask

  task automatic t_nesting();
    do_reset();
    cyc(8'h25, 1, 0, 0, 0);
    expect_out("R5 R6 highest of 0x25", 1, 5);
    cyc(8'h00, 0, 0, 1, 0);
    expect_out("R9 lower waits", 0, 0);
    chk("R5 level shows 2", int'(irqLevel), 2);
    cyc(8'h80, 1, 0, 0, 0);
    expect_out("R8 level 7 nests", 1, 7);
    cyc(8'h00, 0, 0, 1, 0);
    expect_out("R7 after ack 7", 0, 0);
    cyc(8'h00, 0, 0, 0, 1);
    expect_out("R10 level 5 still active", 0, 0);
    cyc(8'h00, 0, 0, 0, 1);
    expect_out("R10 level 2 released", 1, 2);
    cyc(8'h00, 0, 0, 1, 0);
    cyc(8'h00, 0, 0, 0, 1);
    expect_out("R10 level 0 released", 1, 0);
  endtask

  task automatic t_same_level();
    do_reset();
    cyc(8'h08, 1, 0, 0, 0);
    cyc(8'h00, 0, 0, 1, 0);
    cyc(8'h08, 1, 0, 0, 0);
    expect_out("R9 equal level waits", 0, 0);
    cyc(8'h00, 0, 0, 0, 1);
    expect_out("R9 equal level after return", 1, 3);
  endtask

  task automatic t_ack_ignored();
    do_reset();
    intEnable = 0;
    cyc(8'h40, 1, 0, 0, 0);
    cyc(8'h00, 0, 0, 1, 0);
    intEnable = 1;
    #1;
    expect_out("R11 ack ignored pending kept", 1, 6);
    cyc(8'h00, 0, 0, 1, 0);
    expect_out("R7 ack moves level", 0, 0);
    cyc(8'h00, 0, 0, 0, 1);
    expect_out("R7 pending was cleared", 0, 0);
  endtask

  initial begin
    t_reset();
    t_sampling();
    t_enable();
    t_nesting();
    t_same_level();
    t_ack_ignored();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule